// File: doc/BRIEF.md
# Five-Layer Window Overlay Compositor

This block sits after a display timing generator and in front of the panel output. On every active pixel it is given the pixel's column and row, together with one candidate pixel from each of five hardware windows. It works out which windows cover that position and stacks them from the lowest index to the highest. The result is one 24-bit colour. A pixel that no window claims takes a programmable background colour.

Window 0 is a plain opaque base layer. Windows 1 to 4 sit above it. Each of them has its own 4-bit alpha for red, green and blue, and an optional colour key that makes matching pixels see-through. Every window is programmed through static configuration ports: an enable bit, an inclusive top-left corner and an inclusive bottom-right corner. Colours are packed as {R[23:16], G[15:8], B[7:0]}. Memory fetch, format unpacking and palette lookup happen upstream of this block.

Top module: `ovl_compositor`

## Requirements
- R1: `outValid` equals `inValid` delayed by two clock edges. While `rstN` is low, `outValid` is 0 and `outColor` is 0.
- R2: Window w covers a pixel when `winLeft[w] <= pixX <= winRight[w]` and `winTop[w] <= pixY <= winBottom[w]`. Both corners are inclusive. The field for window w sits at bits `[w*COORD_W +: COORD_W]`.
- R3: A window whose `winEnable[w]` bit is 0 has no effect on the output colour.
- R4: A window whose `layerValid[w]` is 0 for a pixel is transparent at that pixel.
- R5: When no window contributes to a pixel, the output is `bgColor`.
- R6: Layers stack by index, so window 4 is on top and window 0 is at the bottom. A layer whose three alpha values are all 0xF replaces everything beneath it exactly.
- R7: Window 0 has no alpha. When it contributes, it replaces the background with its own pixel.
- R8: For windows 1 to 4, each channel becomes `(a*top + (15-a)*below)/15`, with the result truncated. Each channel uses its own alpha. Window k's alpha is at `winAlpha[(k-1)*12 +: 12]` as {R, G, B}, with 4 bits each.
- R9: For window k from 1 to 4, when `keyEnable[k-1]` is 1 and that window's pixel equals `keyColor[(k-1)*24 +: 24]`, the window is transparent at that pixel. Window 0 is never keyed.
- R10: A channel alpha of 0 leaves the layer below unchanged in that channel.
- R11: On a cycle where `outValid` is 0, `outColor` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An active pixel is presented this cycle |
| pixX | input | COORD_W | Pixel column |
| pixY | input | COORD_W | Pixel row |
| winEnable | input | 5 | Per-window enable |
| winLeft | input | 5*COORD_W | Per-window left column, inclusive |
| winTop | input | 5*COORD_W | Per-window top row, inclusive |
| winRight | input | 5*COORD_W | Per-window right column, inclusive |
| winBottom | input | 5*COORD_W | Per-window bottom row, inclusive |
| winAlpha | input | 4*3*ALPHA_W | {R,G,B} alpha for windows 1..4 |
| keyEnable | input | 4 | Colour key enable for windows 1..4 |
| keyColor | input | 4*3*CH_W | Colour key value for windows 1..4 |
| bgColor | input | 3*CH_W | Background colour |
| layerValid | input | 5 | Per-window pixel present |
| layerPixel | input | 5*3*CH_W | Per-window pixel colour |
| outValid | output | 1 | Composed pixel valid |
| outColor | output | 3*CH_W | Composed pixel colour |

## Verification
A pixel's inputs are captured at the first clock edge after they are presented. The composed colour appears in the register outputs after the second edge. So every result, including the hold value on idle cycles, is due exactly two edges after its stimulus. The bench keeps a queue of behaviourally computed expectations and holds one entry in flight after reset release. It pops one entry per clock, shortly after the edge, so each comparison lands in the cycle in which that pixel's result is due. Configuration is changed only between pixels, and each pixel carries its own snapshot into the expectation.

// File: rtl/ovl_comp_pkg.sv
package ovl_comp_pkg;
  localparam int NUM_WIN   = 5;
  localparam int KEYED_WIN = NUM_WIN - 1;

  // strobes from the coverage control to the blend datapath
  typedef struct packed {
    logic                pixStb;
    logic [NUM_WIN-1:0]  layerOn;
  } ovlStrobe_t;
endpackage

// File: rtl/ovl_cover_ctrl.sv
module ovl_cover_ctrl
  import ovl_comp_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CH_W    = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  input  logic [COORD_W-1:0]             pixX,
  input  logic [COORD_W-1:0]             pixY,
  input  logic [NUM_WIN-1:0]             winEnable,
  input  logic [NUM_WIN*COORD_W-1:0]     winLeft,
  input  logic [NUM_WIN*COORD_W-1:0]     winTop,
  input  logic [NUM_WIN*COORD_W-1:0]     winRight,
  input  logic [NUM_WIN*COORD_W-1:0]     winBottom,
  input  logic [KEYED_WIN-1:0]           keyEnable,
  input  logic [KEYED_WIN*3*CH_W-1:0]    keyColor,
  input  logic [NUM_WIN-1:0]             layerValid,
  input  logic [NUM_WIN*3*CH_W-1:0]      layerPixel,
  output ovlStrobe_t                     stb
);
  localparam int PIX_W = 3 * CH_W;

  logic [NUM_WIN-1:0] onNext;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic inX, inY, keyHit;
    assign inX = (pixX >= winLeft[w*COORD_W +: COORD_W]) &&
                 (pixX <= winRight[w*COORD_W +: COORD_W]);
    assign inY = (pixY >= winTop[w*COORD_W +: COORD_W]) &&
                 (pixY <= winBottom[w*COORD_W +: COORD_W]);
    if (w == 0) begin : g_base
      assign keyHit = 1'b0;
    end else begin : g_keyed
      assign keyHit = keyEnable[w-1] &&
        (layerPixel[w*PIX_W +: PIX_W] == keyColor[(w-1)*PIX_W +: PIX_W]);
    end
    assign onNext[w] = winEnable[w] & inX & inY & layerValid[w] & ~keyHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb <= '0;
    end else begin
      stb.pixStb  <= inValid;
      stb.layerOn <= inValid ? onNext : '0;
    end
  end
endmodule

// File: rtl/ovl_blend_dp.sv
module ovl_blend_dp
  import ovl_comp_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int ALPHA_W = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic [NUM_WIN*3*CH_W-1:0]       layerPixel,
  input  logic [KEYED_WIN*3*ALPHA_W-1:0]  winAlpha,
  input  logic [3*CH_W-1:0]               bgColor,
  input  ovlStrobe_t                      stb,
  output logic                            outValid,
  output logic [3*CH_W-1:0]               outColor
);
  localparam int PIX_W     = 3 * CH_W;
  localparam int SET_W     = 3 * ALPHA_W;
  localparam int ALPHA_MAX = (1 << ALPHA_W) - 1;
  localparam int SUM_W     = CH_W + ALPHA_W + 1;

  logic [NUM_WIN*PIX_W-1:0]   pixReg;
  logic [KEYED_WIN*SET_W-1:0] alphaReg;
  logic [PIX_W-1:0]           bgReg;

  // snapshot of colour inputs taken with the pixel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixReg   <= '0;
      alphaReg <= '0;
      bgReg    <= '0;
    end else if (inValid) begin
      pixReg   <= layerPixel;
      alphaReg <= winAlpha;
      bgReg    <= bgColor;
    end
  end

  function automatic logic [CH_W-1:0] mixCh(input logic [CH_W-1:0] top,
                                           input logic [CH_W-1:0] below,
                                           input logic [ALPHA_W-1:0] a);
    logic [SUM_W-1:0] aW, tW, bW, sum, quo;
    aW  = SUM_W'(a);
    tW  = SUM_W'(top);
    bW  = SUM_W'(below);
    sum = aW * tW + (SUM_W'(ALPHA_MAX) - aW) * bW;
    quo = sum / SUM_W'(ALPHA_MAX);
    return quo[CH_W-1:0];
  endfunction

  logic [PIX_W-1:0] stackCol [NUM_WIN+1];
  assign stackCol[0] = bgReg;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_layer
    if (w == 0) begin : g_opaque
      assign stackCol[1] = stb.layerOn[0] ? pixReg[0 +: PIX_W] : stackCol[0];
    end else begin : g_alpha
      logic [PIX_W-1:0] mixed;
      always_comb begin
        for (int c = 0; c < 3; c++) begin
          mixed[c*CH_W +: CH_W] = mixCh(pixReg[w*PIX_W + c*CH_W +: CH_W],
                                        stackCol[w][c*CH_W +: CH_W],
                                        alphaReg[(w-1)*SET_W + c*ALPHA_W +: ALPHA_W]);
        end
      end
      assign stackCol[w+1] = stb.layerOn[w] ? mixed : stackCol[w];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outColor <= '0;
    end else begin
      outValid <= stb.pixStb;
      if (stb.pixStb) outColor <= stackCol[NUM_WIN];
    end
  end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_comp_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CH_W    = 8,
  parameter int ALPHA_W = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic [COORD_W-1:0]              pixX,
  input  logic [COORD_W-1:0]              pixY,
  input  logic [NUM_WIN-1:0]              winEnable,
  input  logic [NUM_WIN*COORD_W-1:0]      winLeft,
  input  logic [NUM_WIN*COORD_W-1:0]      winTop,
  input  logic [NUM_WIN*COORD_W-1:0]      winRight,
  input  logic [NUM_WIN*COORD_W-1:0]      winBottom,
  input  logic [KEYED_WIN*3*ALPHA_W-1:0]  winAlpha,
  input  logic [KEYED_WIN-1:0]            keyEnable,
  input  logic [KEYED_WIN*3*CH_W-1:0]     keyColor,
  input  logic [3*CH_W-1:0]               bgColor,
  input  logic [NUM_WIN-1:0]              layerValid,
  input  logic [NUM_WIN*3*CH_W-1:0]       layerPixel,
  output logic                            outValid,
  output logic [3*CH_W-1:0]               outColor
);
  ovlStrobe_t stb;

  ovl_cover_ctrl #(.COORD_W(COORD_W), .CH_W(CH_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pixX(pixX), .pixY(pixY),
    .winEnable(winEnable), .winLeft(winLeft), .winTop(winTop),
    .winRight(winRight), .winBottom(winBottom), .keyEnable(keyEnable),
    .keyColor(keyColor), .layerValid(layerValid), .layerPixel(layerPixel),
    .stb(stb)
  );

  ovl_blend_dp #(.CH_W(CH_W), .ALPHA_W(ALPHA_W)) i_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .layerPixel(layerPixel),
    .winAlpha(winAlpha), .bgColor(bgColor), .stb(stb),
    .outValid(outValid), .outColor(outColor)
  );
endmodule

// File: rtl/ovl_compositor_chk.sv
module ovl_compositor_chk
  import ovl_comp_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CH_W    = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic [COORD_W-1:0]    pixX,
  input logic [COORD_W-1:0]    pixY,
  input logic [NUM_WIN-1:0]    winEnable,
  input logic [COORD_W-1:0]    left0,
  input logic [COORD_W-1:0]    top0,
  input logic [COORD_W-1:0]    right0,
  input logic [COORD_W-1:0]    bottom0,
  input logic                  valid0,
  input logic [3*CH_W-1:0]     base0Pixel,
  input logic [3*CH_W-1:0]     bgColor,
  input logic                  outValid,
  input logic [3*CH_W-1:0]     outColor
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  logic noneOn, w0Solo;
  assign noneOn = inValid && (winEnable == '0);
  assign w0Solo = inValid && (winEnable == NUM_WIN'(1)) && valid0 &&
                  (pixX >= left0) && (pixX <= right0) &&
                  (pixY >= top0) && (pixY <= bottom0);

  // R1
  always @(negedge clk) begin
    if (!rstN) reset_quiet_chk: assert (!outValid && outColor == '0);
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (outValid == $past(inValid, 2)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && !outValid) |-> $stable(outColor));

  // R5
  background_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && $past(noneOn, 2)) |-> (outColor == $past(bgColor, 2)));

  // R7
  base_opaque_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && $past(w0Solo, 2)) |-> (outColor == $past(base0Pixel, 2)));
endmodule

bind ovl_compositor ovl_compositor_chk #(.COORD_W(COORD_W), .CH_W(CH_W)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .pixX(pixX), .pixY(pixY),
  .winEnable(winEnable),
  .left0(winLeft[COORD_W-1:0]), .top0(winTop[COORD_W-1:0]),
  .right0(winRight[COORD_W-1:0]), .bottom0(winBottom[COORD_W-1:0]),
  .valid0(layerValid[0]), .base0Pixel(layerPixel[3*CH_W-1:0]),
  .bgColor(bgColor), .outValid(outValid), .outColor(outColor)
);

// File: tb/test_ovl_compositor.sv
`timescale 1ns/1ps
module test_ovl_compositor;
  localparam int CW = 12;
  localparam int NW = 5;
  localparam int PW = 24;

  logic clk = 1'b0;
  logic rstN;
  logic inValid;
  logic [CW-1:0] pixX, pixY;
  logic [NW-1:0] winEnable;
  logic [NW*CW-1:0] winLeft, winTop, winRight, winBottom;
  logic [(NW-1)*12-1:0] winAlpha;
  logic [NW-2:0] keyEnable;
  logic [(NW-1)*PW-1:0] keyColor;
  logic [PW-1:0] bgColor;
  logic [NW-1:0] layerValid;
  logic [NW*PW-1:0] layerPixel;
  logic outValid;
  logic [PW-1:0] outColor;

  int checks = 0;
  int fails = 0;
  logic [PW-1:0] lastCol = '0;

  typedef struct { bit v; logic [PW-1:0] c; string req; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  ovl_compositor i_ovl_compositor (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pixX(pixX), .pixY(pixY),
    .winEnable(winEnable), .winLeft(winLeft), .winTop(winTop),
    .winRight(winRight), .winBottom(winBottom), .winAlpha(winAlpha),
    .keyEnable(keyEnable), .keyColor(keyColor), .bgColor(bgColor),
    .layerValid(layerValid), .layerPixel(layerPixel),
    .outValid(outValid), .outColor(outColor)
  );

  // behavioural expectation straight from the requirements
  function automatic logic [PW-1:0] refColor();
    int acc[3];
    for (int c = 0; c < 3; c++) acc[c] = int'(bgColor[c*8 +: 8]);
    for (int w = 0; w < NW; w++) begin
      logic [PW-1:0] p;
      p = layerPixel[w*PW +: PW];
      if (winEnable[w] && layerValid[w] &&
          pixX >= winLeft[w*CW +: CW] && pixX <= winRight[w*CW +: CW] &&
          pixY >= winTop[w*CW +: CW] && pixY <= winBottom[w*CW +: CW]) begin
        if (w == 0) begin
          for (int c = 0; c < 3; c++) acc[c] = int'(p[c*8 +: 8]);
        end else if (!(keyEnable[w-1] && p == keyColor[(w-1)*PW +: PW])) begin
          for (int c = 0; c < 3; c++) begin
            int a;
            a = int'(winAlpha[(w-1)*12 + c*4 +: 4]);
            acc[c] = (a * int'(p[c*8 +: 8]) + (15 - a) * acc[c]) / 15;
          end
        end
      end
    end
    return {acc[2][7:0], acc[1][7:0], acc[0][7:0]};
  endfunction

  task automatic tick(input string req);
    exp_t e;
    e.v = inValid;
    e.c = refColor();
    e.req = req;
    q.push_back(e);
    @(posedge clk);
    #1;
    e = q.pop_front();
    if (e.v) lastCol = e.c;
    checks++;
    if (outValid !== e.v || outColor !== lastCol) begin
      fails++;
      $display("FAIL %s: outValid=%0b outColor=%06h expected outValid=%0b outColor=%06h",
               e.req, outValid, outColor, e.v, lastCol);
    end
  endtask

  task automatic pixel(input int x, input int y, input string req);
    pixX = CW'(x);
    pixY = CW'(y);
    inValid = 1'b1;
    tick(req);
  endtask

  task automatic idle(input int n, input string req);
    inValid = 1'b0;
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic setWin(input int w, input bit en, input int l, input int t,
                        input int r, input int b, input logic [PW-1:0] p);
    winEnable[w] = en;
    winLeft[w*CW +: CW] = CW'(l);
    winTop[w*CW +: CW] = CW'(t);
    winRight[w*CW +: CW] = CW'(r);
    winBottom[w*CW +: CW] = CW'(b);
    layerPixel[w*PW +: PW] = p;
  endtask

  task automatic setAlpha(input int w, input logic [3:0] ar, input logic [3:0] ag,
                          input logic [3:0] ab);
    winAlpha[(w-1)*12 +: 12] = {ar, ag, ab};
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; pixX = '0; pixY = '0;
    winEnable = '0; winLeft = '0; winTop = '0; winRight = '0; winBottom = '0;
    winAlpha = '0; keyEnable = '0; keyColor = '0; bgColor = '0;
    layerValid = '0; layerPixel = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    checks++;
    if (outValid !== 1'b0 || outColor !== '0) begin
      fails++;
      $display("FAIL R1: reset outValid=%0b outColor=%06h expected 0 000000",
               outValid, outColor);
    end
    rstN = 1'b1;
    begin
      exp_t e0;
      e0.v = 1'b0; e0.c = '0; e0.req = "R1";
      q.push_back(e0);
    end

    // R5 background with nothing enabled
    bgColor = 24'h0A0B0C;
    pixel(0, 0, "R5");
    pixel(100, 50, "R5");

    // R2 inclusive corners, R7 opaque base
    layerValid = '1;
    setWin(0, 1'b1, 10, 20, 13, 22, 24'h102030);
    for (int x = 9; x <= 14; x++) pixel(x, 20, "R2");
    pixel(11, 19, "R2");
    pixel(11, 22, "R2");
    pixel(11, 23, "R2");
    pixel(10, 20, "R7");
    pixel(13, 22, "R7");

    // R3 disabled window
    winEnable[0] = 1'b0;
    pixel(11, 21, "R3");
    winEnable[0] = 1'b1;

    // R4 layer pixel not present
    layerValid[0] = 1'b0;
    pixel(11, 21, "R4");
    layerValid[0] = 1'b1;

    // R6 stacking order and full alpha
    setWin(3, 1'b1, 11, 20, 12, 21, 24'hC0FFEE);
    setAlpha(3, 4'hF, 4'hF, 4'hF);
    setWin(4, 1'b1, 12, 21, 14, 21, 24'h445566);
    setAlpha(4, 4'hF, 4'hF, 4'hF);
    pixel(11, 20, "R6");
    pixel(12, 21, "R6");
    pixel(13, 21, "R6");
    pixel(14, 21, "R6");

    // R10 zero alpha on top leaves lower layer
    setAlpha(4, 4'h0, 4'h0, 4'h0);
    pixel(12, 21, "R10");
    pixel(14, 21, "R10");
    setAlpha(4, 4'h0, 4'h7, 4'hF);
    pixel(12, 21, "R10");

    // R8 partial per-channel blend
    winEnable[3] = 1'b0;
    winEnable[4] = 1'b0;
    setWin(1, 1'b1, 10, 20, 13, 22, 24'hF08040);
    setAlpha(1, 4'h8, 4'h3, 4'h0);
    pixel(11, 21, "R8");
    setAlpha(1, 4'h5, 4'hF, 4'hA);
    pixel(12, 22, "R8");
    setWin(3, 1'b1, 12, 22, 12, 22, 24'h01FE80);
    setAlpha(3, 4'h9, 4'h1, 4'hE);
    pixel(12, 22, "R8");
    winEnable[3] = 1'b0;

    // R9 colour key
    winEnable[1] = 1'b0;
    setWin(2, 1'b1, 10, 20, 13, 22, 24'h777777);
    setAlpha(2, 4'hF, 4'hF, 4'hF);
    keyEnable[1] = 1'b1;
    keyColor[1*PW +: PW] = 24'h777777;
    pixel(11, 21, "R9");
    layerPixel[2*PW +: PW] = 24'h777778;
    pixel(11, 21, "R9");
    layerPixel[2*PW +: PW] = 24'h777777;
    keyEnable[1] = 1'b0;
    pixel(11, 21, "R9");
    winEnable[2] = 1'b0;
    keyEnable[0] = 1'b1;
    keyColor[0 +: PW] = 24'h102030;
    pixel(11, 21, "R9");

    // R11 hold on idle cycles while inputs move
    pixel(11, 21, "R11");
    idle(1, "R11");
    pixX = 0;
    bgColor = 24'h999999;
    idle(2, "R11");
    pixel(0, 0, "R11");
    inValid = 1'b0;
    pixX = 11; pixY = 21;
    idle(3, "R11");

    // R1 back-to-back then drain
    pixel(10, 22, "R1");
    pixel(50, 50, "R1");
    idle(2, "R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule